// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the station-management side of a PHY management link. It produces the management clock and serializes complete register-access frames onto one shared, tri-stateable data line, so that a host can read or write 16-bit registers in an external PHY. A request carries a read/write selector, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block accepts it when idle and sends the frame. On reads it releases the line for the turnaround and data fields, then captures the 16 returned bits. It ends with a one-cycle completion pulse, the captured value and a missing-responder flag.

The management clock is the system clock divided by a build-time parameter. Each half period lasts `HALF_DIV` system cycles, and the clock rests low between frames. The data line is presented as separate output, output-enable and input signals, so a pad cell at the chip edge can form the bidirectional pin.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 bits of logic one, all driven (output enable high), sent while the management clock runs.
- R2: The preamble is followed by the start bits 0 then 1 and a 2-bit opcode, where 01 means write and 10 means read. Every field is sent most significant bit first.
- R3: After the opcode come the 5-bit PHY address and then the 5-bit register address, both driven.
- R4: On a write the block drives the turnaround bits 1 then 0 and then the 16 write-data bits, so all 64 frame bits are driven.
- R5: On a read the output enable drops at the first turnaround bit (bit 46 of the 64) and stays low to the end of the frame. The block samples the line on management-clock rising edges, and the 16 bits sampled during the data field, first received in the top position, become `rd_data` at completion. A write completes with `rd_data` equal to zero.
- R6: On a read, if the line is sampled as 1 during the second turnaround bit, `no_resp` is 1 at completion. Otherwise it is 0, and it is always 0 after a write.
- R7: The management clock has a period of 2·`HALF_DIV` system cycles while a frame runs and is low whenever the block is idle. The data output and its enable change only at the system edge where the management clock falls, never while it is high.
- R8: `busy` rises on the cycle after an accepted request and stays high through exactly 64 management-clock rising edges. A request presented while busy is ignored: it neither changes the frame in progress nor starts another one.
- R9: `done` is a one-cycle pulse that comes in the cycle `busy` falls. `rd_data` and `no_resp` change only in a cycle where `done` is high.
- R10: After reset and between frames the output enable is low, the management clock is low, and `busy`, `done`, `rd_data` and `no_resp` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 selects a read, 0 a write |
| req_phy | input | 5 | Target PHY address |
| req_reg | input | 5 | Target register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Value captured by the last read |
| no_resp | output | 1 | Second turnaround bit was not 0 on the last read |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_in | input | 1 | Data line input value |

## Verification
The assertions check on every cycle the properties that hold at any time: the clock and output enable stay at rest while idle, the output and enable hold while the management clock is high, the output stays released once a read has let go of the line, done is a single pulse tied to the fall of busy, and the results hold between completions. The content of a frame can only be shown by the bench's scenarios, in which a PHY model records each bit on the rising clock edges and answers reads. Those scenarios cover the bit order of every field, the turnaround pattern for each direction, the captured read value, the missing-PHY flag, the clock period, and a request ignored in the middle of a frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 4;
    localparam int TA_BITS    = 2;
    localparam int FRAME_BITS = PRE_BITS + HDR_BITS + 2 * ADDR_W + TA_BITS + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_FIRST   = PRE_BITS + HDR_BITS + 2 * ADDR_W;
    localparam int TA_LAST    = TA_FIRST + 1;
    localparam int DATA_FIRST = TA_FIRST + TA_BITS;

    localparam logic [1:0] SOF_CODE  = 2'b01;
    localparam logic [1:0] TA_DRIVEN = 2'b10;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FRAME = 1'b1
    } mdio_state_e;

    typedef struct packed {
        mdio_op_e          op;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_req_t;

    // Whole frame, first bit on the wire in the top position.
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_req_t r);
        logic [TA_BITS-1:0] ta;
        logic [DATA_W-1:0]  d;
        ta = (r.op == OP_WRITE) ? TA_DRIVEN : '0;
        d  = (r.op == OP_WRITE) ? r.wdata : '0;
        return {{PRE_BITS{1'b1}}, SOF_CODE, r.op, r.phy, r.regad, ta, d};
    endfunction
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == CW'(HALF_DIV - 1));
    assign rise_evt = wrap && !mdc;
    assign fall_evt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             fall_evt,
    output logic             busy,
    output logic             load,
    output logic             finish,
    output logic             done,
    output logic [IDX_W-1:0] bit_idx
);
    mdio_state_e state;

    assign busy   = (state == ST_FRAME);
    assign load   = req_valid && !busy;
    assign finish = fall_evt && (bit_idx == IDX_W'(FRAME_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= finish;
            if (load) begin
                state   <= ST_FRAME;
                bit_idx <= '0;
            end else if (finish) begin
                state   <= ST_IDLE;
                bit_idx <= '0;
            end else if (fall_evt) begin
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_shift.sv
module mdio_shift
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  mdio_req_t         req,
    input  logic              busy,
    input  logic              rise_evt,
    input  logic              fall_evt,
    input  logic              finish,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp
);
    logic [FRAME_BITS-1:0] sh;
    logic                  is_rd;
    logic [DATA_W-1:0]     rx;
    logic                  ta_bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            is_rd   <= 1'b0;
            rx      <= '0;
            ta_bad  <= 1'b0;
            rd_data <= '0;
            no_resp <= 1'b0;
        end else begin
            if (load) begin
                sh     <= build_frame(req);
                is_rd  <= (req.op == OP_READ);
                rx     <= '0;
                ta_bad <= 1'b0;
            end else if (fall_evt) begin
                sh <= {sh[FRAME_BITS-2:0], 1'b0};
            end
            if (rise_evt && is_rd) begin
                if (bit_idx == IDX_W'(TA_LAST))
                    ta_bad <= mdio_in;
                if (bit_idx >= IDX_W'(DATA_FIRST))
                    rx <= {rx[DATA_W-2:0], mdio_in};
            end
            if (finish) begin
                rd_data <= rx;
                no_resp <= ta_bad;
            end
        end
    end

    assign mdio_out = sh[FRAME_BITS-1];
    assign mdio_oe  = busy && !(is_rd && (bit_idx >= IDX_W'(TA_FIRST)));
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_read,
    input  logic [ADDR_W-1:0] req_phy,
    input  logic [ADDR_W-1:0] req_reg,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);
    mdio_req_t        req;
    logic             load;
    logic             finish;
    logic             rise_evt;
    logic             fall_evt;
    logic [IDX_W-1:0] bit_idx;

    always_comb begin
        req.op    = req_read ? OP_READ : OP_WRITE;
        req.phy   = req_phy;
        req.regad = req_reg;
        req.wdata = req_wdata;
    end

    mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_clkdiv (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    mdio_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .fall_evt  (fall_evt),
        .busy      (busy),
        .load      (load),
        .finish    (finish),
        .done      (done),
        .bit_idx   (bit_idx)
    );

    mdio_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .req      (req),
        .busy     (busy),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .finish   (finish),
        .bit_idx  (bit_idx),
        .mdio_in  (mdio_in),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .rd_data  (rd_data),
        .no_resp  (no_resp)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic [15:0] rd_data,
    input logic        no_resp
);
    p_mdc_rest_r7: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    p_out_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    p_line_free_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    p_stay_released_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

    p_busy_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_with_fall_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_result_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rd_data) && $stable(no_resp)));
endmodule

bind mdio_master mdio_master_chk u_mdio_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mdc      (mdc),
    .mdio_out (mdio_out),
    .mdio_oe  (mdio_oe),
    .rd_data  (rd_data),
    .no_resp  (no_resp)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
    localparam int DIV = 3;

    typedef struct {
        logic        rd;
        logic [63:0] bits;
        logic [15:0] rdv;
        logic        nr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_read = 1'b0;
    logic [4:0]  req_phy = '0;
    logic [4:0]  req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, no_resp, mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_in = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    exp_t q[$];

    logic [15:0] resp_data = '0;
    logic        resp_ta = 1'b0;

    logic [63:0] cap_out, cap_oe;
    int          k = 0;
    int          cyc = 0;
    int          last_rise = 0;
    logic        period_bad = 1'b0;
    logic        prev_mdc = 1'b0;
    int          done_seen = 0;

    mdio_master #(.HALF_DIV(DIV)) u_mdio_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_read(req_read),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic resp_bit(input int idx);
        if (idx < 47) return 1'b1;
        if (idx == 47) return resp_ta;
        if (idx < 64) return resp_data[63 - idx];
        return 1'b1;
    endfunction

    // PHY model and monitor
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog got timeout exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
        if (!rst) begin
            if (mdc && !prev_mdc) begin
                if (k > 0 && (cyc - last_rise) != 2 * DIV) period_bad = 1'b1;
                last_rise = cyc;
                if (k < 64) begin
                    cap_out[63 - k] = mdio_out;
                    cap_oe[63 - k]  = mdio_oe;
                end
                k++;
                mdio_in = resp_bit(k);
            end
            if (done) begin
                done_seen++;
                if (q.size() == 0) begin
                    chk("R9 unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk("R1 preamble", {cap_out[63:32], cap_oe[63:32]}, {32'hFFFF_FFFF, 32'hFFFF_FFFF});
                    chk("R2 start and opcode", 64'(cap_out[31:28]), 64'(e.bits[31:28]));
                    chk("R3 addresses", 64'(cap_out[27:18]), 64'(e.bits[27:18]));
                    chk("R3 address fields driven", 64'(cap_oe[31:18]), 64'h3FFF);
                    if (e.rd) begin
                        chk("R5 release pattern", 64'(cap_oe[17:0]), 64'h0);
                        chk("R5 read data", 64'(rd_data), 64'(e.rdv));
                    end else begin
                        chk("R4 write tail", 64'(cap_out[17:0]), 64'(e.bits[17:0]));
                        chk("R4 write driven", 64'(cap_oe[17:0]), 64'h3FFFF);
                        chk("R5 write result zero", 64'(rd_data), 64'h0);
                    end
                    chk("R6 no_resp", 64'(no_resp), 64'(e.nr));
                    chk("R7 mdc period", 64'(period_bad), 64'h0);
                    chk("R8 rising edges per frame", 64'(k), 64'd64);
                    chk("R9 busy low at done", 64'(busy), 64'h0);
                end
                k = 0;
                period_bad = 1'b0;
                mdio_in = 1'b1;
            end
        end
        prev_mdc = mdc;
    end

    task automatic issue(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic [15:0] rsp, input logic ta);
        exp_t e;
        while (busy || q.size() != 0) @(negedge clk);
        resp_data = rsp;
        resp_ta   = ta;
        e.rd   = rd;
        e.bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                  (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : wd)};
        e.rdv  = rd ? rsp : 16'h0;
        e.nr   = rd ? ta : 1'b0;
        q.push_back(e);
        req_valid = 1'b1;
        req_read  = rd;
        req_phy   = phy;
        req_reg   = rg;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset idle outputs", {58'h0, busy, done, mdc, mdio_oe, no_resp, |rd_data}, 64'h0);
        chk("R10 reset rd_data", 64'(rd_data), 64'h0);

        issue(1'b0, 5'h1F, 5'h00, 16'hA5C3, 16'h0, 1'b0);
        issue(1'b1, 5'h00, 5'h1F, 16'h0, 16'h8001, 1'b0);
        issue(1'b1, 5'h0A, 5'h15, 16'h0, 16'hFFFF, 1'b1);
        issue(1'b0, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0);
        issue(1'b1, 5'h0A, 5'h15, 16'h0, 16'h5A3C, 1'b0);

        // R8: a request in mid-frame must be ignored
        issue(1'b0, 5'h12, 5'h0C, 16'h1234, 16'h0, 1'b0);
        repeat (100) @(negedge clk);
        req_valid = 1'b1; req_read = 1'b1; req_phy = 5'h03; req_reg = 5'h07; req_wdata = 16'hFFFF;
        @(negedge clk);
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
        chk("R8 ignored request starts nothing", {62'h0, busy, mdc}, 64'h0);
        chk("R8 ignored request no extra done", 64'(done_seen), 64'd6);
        chk("R10 line released when idle", 64'(mdio_oe), 64'h0);

        // back-to-back after completion
        issue(1'b1, 5'h15, 5'h0A, 16'h0, 16'h0F0F, 1'b0);
        issue(1'b0, 5'h01, 5'h1E, 16'hFFFF, 16'h0, 1'b0);
        while (q.size() != 0 || busy) @(negedge clk);
        repeat (5) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule